// File: doc/BRIEF.md
# Sliding-Window Column Feeder

This block sits in front of a matrix engine that consumes a complete 3-column pixel window on every step, while the link feeding it carries only one fresh column per step. Each accepted column is appended to a short history of the two columns that came before it, so a window moving across a row with stride 1 costs three new pixels per step instead of nine. That cuts the input traffic by about two thirds, because consecutive windows share six pixels.

A small state machine counts how many columns the current row has delivered. Its states are EMPTY (no history), ONE (one column held), TWO (two columns held) and FULL (a window can be formed). An accepted column moves EMPTY to ONE, ONE to TWO and TWO to FULL, and FULL stays FULL. A cycle without valid input keeps the state. A row-start pulse flushes the history. It returns the machine to EMPTY, or to ONE when a column arrives in the same cycle. The assembled window goes into registers and is copied to every broadcast port, one cycle after the column that completes it.

Top module: `sw_window_feed`

## Requirements
- R1: After reset every port shows win_valid low and win_data all zero.
- R2: A column is accepted only in a cycle with in_valid high. Within in_col, row r (0 = top) occupies bits [r*PIX_W +: PIX_W].
- R3: In each port's WIN_W-bit window, pixel (column c, row r) sits at bits [(c*ROWS+r)*PIX_W +: PIX_W]. Column 0 is the oldest and column 2 is the newest.
- R4: The first window of a row appears on the outputs one cycle after the third column accepted since reset or since the last row start. Earlier columns produce no valid window.
- R5: With the history full, every accepted column produces a window one cycle later. That window shifts by one column: the previous window's newest column becomes its middle column.
- R6: A cycle with in_valid low leaves the history unchanged. It drives win_valid low in the next cycle, and win_data keeps its last value.
- R7: row_start discards the history. With in_valid high in the same cycle, the column becomes the first of the new row. Otherwise the next accepted column is the first.
- R8: All NUM_PORTS broadcast ports carry identical valid and window data in every cycle.
- R9: The fill state machine follows EMPTY -> ONE -> TWO -> FULL on accepted columns. It holds on idle cycles, and only FULL or TWO with an accepted column fires a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New column present on in_col |
| row_start | input | 1 | Flush the history; a column arriving with it starts the new row |
| in_col | input | ROWS*PIX_W | New column, top pixel in the low bits |
| win_valid | output | NUM_PORTS | Window valid, one bit per broadcast port |
| win_data | output | NUM_PORTS*3*ROWS*PIX_W | Window per port, port p at slice p*WIN_W |

## Verification
The bench builds the block with its defaults: 4-bit pixels, 3-pixel columns and 4 broadcast ports. Every port slice is therefore compared against one expected window, which exposes any port that is wired or registered apart from the others. With a 4-bit pixel, each column value is easy to tell apart. A swap of rows or columns, or a window left with a stale middle column, shows up directly. Idle gaps, row starts with and without a column, and row starts issued from a full history reach every state transition.

// File: rtl/swf_pkg.sv
package swf_pkg;
    localparam int WIN_COLS = 3;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_ONE   = 2'd1,
        S_TWO   = 2'd2,
        S_FULL  = 2'd3
    } fill_state_t;
endpackage

// File: rtl/swf_fill_fsm.sv
module swf_fill_fsm
    import swf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        row_start,
    output fill_state_t state,
    output logic        fire
);
    fill_state_t next_state;

    always_comb begin
        next_state = state;
        if (row_start) begin
            next_state = in_valid ? S_ONE : S_EMPTY;
        end else if (in_valid) begin
            unique case (state)
                S_EMPTY: next_state = S_ONE;
                S_ONE:   next_state = S_TWO;
                S_TWO:   next_state = S_FULL;
                S_FULL:  next_state = S_FULL;
                default: next_state = S_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= next_state;
    end

    always_comb begin
        fire = 1'b0;
        unique case (state)
            S_EMPTY: fire = 1'b0;
            S_ONE:   fire = 1'b0;
            S_TWO:   fire = in_valid && !row_start;
            S_FULL:  fire = in_valid && !row_start;
            default: fire = 1'b0;
        endcase
    end

    // R9
    fill_empty_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY && in_valid && !row_start) |=> state == S_ONE);
    // R9
    fill_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !row_start) |=> $stable(state));
    // R7
    fill_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (state == S_EMPTY || state == S_ONE));
endmodule

// File: rtl/swf_col_history.sv
module swf_col_history #(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             flush,
    input  logic [COL_W-1:0] in_col,
    output logic [COL_W-1:0] col_old,
    output logic [COL_W-1:0] col_prev
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_old  <= '0;
            col_prev <= '0;
        end else if (flush) begin
            col_old  <= '0;
            col_prev <= shift_en ? in_col : '0;
        end else if (shift_en) begin
            col_old  <= col_prev;
            col_prev <= in_col;
        end
    end

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !flush) |=> ($stable(col_old) && $stable(col_prev)));
    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !flush) |=> col_old == $past(col_prev));
endmodule

// File: rtl/swf_broadcast.sv
module swf_broadcast #(
    parameter int WIN_W     = 36,
    parameter int NUM_PORTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fire,
    input  logic [WIN_W-1:0]           window,
    output logic [NUM_PORTS-1:0]       port_valid,
    output logic [NUM_PORTS*WIN_W-1:0] port_data
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_valid[p]                 <= 1'b0;
                port_data[p*WIN_W +: WIN_W]   <= '0;
            end else begin
                port_valid[p] <= fire;
                if (fire) port_data[p*WIN_W +: WIN_W] <= window;
            end
        end

        // R8
        port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (port_valid[p] == port_valid[0]) &&
            (port_data[p*WIN_W +: WIN_W] == port_data[0 +: WIN_W]));
    end
endmodule

// File: rtl/sw_window_feed.sv
module sw_window_feed
    import swf_pkg::*;
#(
    parameter int PIX_W     = 4,
    parameter int ROWS      = 3,
    parameter int NUM_PORTS = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic                                    row_start,
    input  logic [ROWS*PIX_W-1:0]                   in_col,
    output logic [NUM_PORTS-1:0]                    win_valid,
    output logic [NUM_PORTS*WIN_COLS*ROWS*PIX_W-1:0] win_data
);
    localparam int COL_W = ROWS * PIX_W;
    localparam int WIN_W = WIN_COLS * COL_W;

    fill_state_t      state;
    logic             fire;
    logic [COL_W-1:0] col_old;
    logic [COL_W-1:0] col_prev;
    logic [WIN_W-1:0] window;

    swf_fill_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .row_start (row_start),
        .state     (state),
        .fire      (fire)
    );

    swf_col_history #(.COL_W(COL_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .flush    (row_start),
        .in_col   (in_col),
        .col_old  (col_old),
        .col_prev (col_prev)
    );

    assign window = {in_col, col_prev, col_old};

    swf_broadcast #(.WIN_W(WIN_W), .NUM_PORTS(NUM_PORTS)) u_bcast (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .window     (window),
        .port_valid (win_valid),
        .port_data  (win_data)
    );

    // R6
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !win_valid[0]);
    // R6
    idle_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(win_data));
    // R7
    flush_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> !win_valid[0]);
    // R3
    newest_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[0] |-> win_data[2*COL_W +: COL_W] == $past(in_col));
    // R5
    slide_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid[0] && $past(win_valid[0])) |->
        win_data[COL_W +: COL_W] == $past(win_data[2*COL_W +: COL_W]));
endmodule

// File: tb/tb_sw_window_feed.sv
module tb_sw_window_feed;
    localparam int PIX_W = 4;
    localparam int ROWS  = 3;
    localparam int PORTS = 4;
    localparam int COL_W = ROWS * PIX_W;
    localparam int WIN_W = 3 * COL_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   row_start = 1'b0;
    logic [COL_W-1:0]       in_col = '0;
    logic [PORTS-1:0]       win_valid;
    logic [PORTS*WIN_W-1:0] win_data;

    int checks = 0;
    int fails  = 0;
    logic [WIN_W-1:0] exp_q[$];
    logic             exp_fire = 1'b0;
    logic [WIN_W-1:0] last_win = '0;
    logic [COL_W-1:0] m_prev = '0;
    logic [COL_W-1:0] m_old  = '0;
    int               m_cnt  = 0;
    logic             done = 1'b0;

    sw_window_feed #(.PIX_W(PIX_W), .ROWS(ROWS), .NUM_PORTS(PORTS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
        .in_col(in_col), .win_valid(win_valid), .win_data(win_data)
    );

    always #10 clk = ~clk;

    // one cycle of stimulus; model computes the expected window from R2-R7
    task automatic step(input logic v, input logic rs, input logic [COL_W-1:0] c);
        @(negedge clk);
        in_valid  = v;
        row_start = rs;
        in_col    = c;
        exp_fire  = 1'b0;
        if (rs) begin
            m_old = '0; m_prev = '0; m_cnt = 0;
        end
        if (v) begin
            if (m_cnt >= 2) begin
                exp_q.push_back({c, m_prev, m_old});
                exp_fire = 1'b1;
            end
            m_old  = m_prev;
            m_prev = c;
            if (m_cnt < 3) m_cnt++;
        end
    endtask

    task automatic mkcol(input int seed, output logic [COL_W-1:0] c);
        for (int r = 0; r < ROWS; r++) c[r*PIX_W +: PIX_W] = 4'((seed * 5 + r * 3 + 1));
    endtask

    // monitor: samples just after the edge that registers the window
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (done) break;
            for (int p = 0; p < PORTS; p++) begin
                checks++;
                if (win_valid[p] !== exp_fire) begin
                    fails++;
                    $display("FAIL R4/R8 port %0d valid: got %b expected %b", p, win_valid[p], exp_fire);
                end
            end
            if (exp_fire) begin
                logic [WIN_W-1:0] e;
                e = exp_q.pop_front();
                last_win = e;
            end
            for (int p = 0; p < PORTS; p++) begin
                checks++;
                if (win_data[p*WIN_W +: WIN_W] !== last_win) begin
                    fails++;
                    $display("FAIL R3/R5/R6 port %0d data: got %h expected %h",
                             p, win_data[p*WIN_W +: WIN_W], last_win);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [COL_W-1:0] c;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (win_valid !== '0 || win_data !== '0) begin
            fails++;
            $display("FAIL R1 reset: got %b/%h expected 0/0", win_valid, win_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R4 R5: a full row with a leading row start
        mkcol(1, c); step(1, 1, c);
        for (int i = 2; i <= 8; i++) begin mkcol(i, c); step(1, 0, c); end
        // R6: idle gaps inside a row
        step(0, 0, '0);
        step(0, 0, 12'hFFF);
        mkcol(9, c); step(1, 0, c);
        step(0, 0, '0);
        mkcol(10, c); step(1, 0, c);
        // R7: row start with a column while full
        mkcol(11, c); step(1, 1, c);
        mkcol(12, c); step(1, 0, c);
        step(0, 0, '0);
        mkcol(13, c); step(1, 0, c);
        mkcol(14, c); step(1, 0, c);
        // R7: row start without a column, then back-to-back starts
        step(0, 1, 12'hABC);
        mkcol(15, c); step(1, 0, c);
        mkcol(16, c); step(1, 0, c);
        step(0, 1, '0);
        mkcol(17, c); step(1, 1, c);
        mkcol(18, c); step(1, 0, c);
        mkcol(19, c); step(1, 0, c);
        // R9: alternating valid pattern in FULL
        for (int i = 20; i < 40; i++) begin mkcol(i, c); step(i[0], 0, c); end
        // R2: distinct row values reveal row swaps
        step(1, 1, 12'h321);
        step(1, 0, 12'h654);
        step(1, 0, 12'h987);
        step(1, 0, 12'hCBA);
        step(0, 0, '0);
        step(0, 0, '0);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4 windows missing: got %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule